// File: doc/BRIEF.md
# Card bus cycle controller

This block runs one external bus cycle at a time on a card-style interface that has separate memory and I/O strobes. A requester presents an address, a direction, write data, a 3-bit space code, a timing-set select bit and an area bit. The block decodes the space code into I/O, common-memory or attribute-memory space at 8 or 16 bits. It then drives chip-select, the low and high card enables, register-select and the address for a programmed number of setup cycles. Next comes a strobe of programmed length, then a programmed hold. It ends with a one-cycle acknowledge that carries read data. A programmed idle gap follows before the next request is taken.

Two register-programmed timing sets exist. Each set holds a base wait, a coded low-speed extra wait, a setup count, a hold count and an idle count. The select bit chooses which set supplies the base wait, extra wait, setup and hold. The idle gap always comes from the set named by the area bit. A request with the reserved space code never reaches the bus and is answered with an error.

Top module: `card_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and rsp_ack, rsp_err, card_cs, card_en_lo, card_en_hi, card_reg, card_wdata_oe and all four strobes are 0.
- R2: card_en_lo is 1 throughout the address window of every accepted non-reserved access. card_en_hi is 1 there only for 16-bit codes, which are the codes with bit 0 set (001, 011, 101, 111).
- R3: card_reg is 1 during the address window only for attribute-memory codes 110 and 111, and 0 for every other code.
- R4: Codes 001, 010 and 011 use card_io_rd or card_io_wr. Codes 100 to 111 use card_mem_rd or card_mem_wr. A read (req_write=0) uses the read strobe and a write uses the write strobe, and at most one strobe is high at any time.
- R5: The strobe stays high for 1 + base + extra cycles. Base is the 3-bit base wait field (0–7). Extra is 0, 15, 30 or 50 for low-speed codes 0, 1, 2 and 3.
- R6: card_cs, the enables, register-select and a stable card_addr are driven for exactly setup cycles (0–15) before the strobe rises. The window starts in the cycle after acceptance.
- R7: The window stays valid for exactly hold cycles (0–15) after the strobe falls.
- R8: With req_tsel=0 the base, low-speed, setup and hold fields come from set A. With req_tsel=1 they come from set B.
- R9: After acknowledge, req_ready stays 0 for the idle count of the set named by req_area (0 selects A, 1 selects B), whatever req_tsel is. req_ready is 0 from acceptance until that gap ends.
- R10: For reads, card_rdata is sampled at the end of the last strobe cycle and shown on rsp_rdata while rsp_ack is 1.
- R11: rsp_ack is high for exactly one cycle, in the cycle after the last hold cycle (or after the last strobe cycle when hold is 0). rsp_err is 0 for non-reserved codes.
- R12: A request with code 000 drives no window and no strobe. rsp_ack and rsp_err are both 1 in the cycle after acceptance, and req_ready returns in the following cycle.
- R13: For writes, card_wdata_oe is 1 and card_wdata equals the request's write data for the whole address window. card_wdata_oe is 0 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_a_base | input | 3 | Set A base strobe wait |
| cfg_a_slow | input | 2 | Set A low-speed extra wait code |
| cfg_a_setup | input | 4 | Set A setup cycles |
| cfg_a_hold | input | 4 | Set A hold cycles |
| cfg_a_idle | input | 3 | Set A idle gap cycles |
| cfg_b_base | input | 3 | Set B base strobe wait |
| cfg_b_slow | input | 2 | Set B low-speed extra wait code |
| cfg_b_setup | input | 4 | Set B setup cycles |
| cfg_b_hold | input | 4 | Set B hold cycles |
| cfg_b_idle | input | 3 | Set B idle gap cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 26 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 3 | Space code |
| req_tsel | input | 1 | Timing set select for wait, setup, hold |
| req_area | input | 1 | Area bit that selects the idle gap set |
| req_wdata | input | 16 | Write data |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Reserved code reported, together with rsp_ack |
| rsp_rdata | output | 16 | Captured read data |
| card_addr | output | 26 | Card address |
| card_cs | output | 1 | Chip select, high in the address window |
| card_en_lo | output | 1 | Low byte card enable |
| card_en_hi | output | 1 | High byte card enable |
| card_reg | output | 1 | Register (attribute) select |
| card_mem_rd | output | 1 | Memory read strobe |
| card_mem_wr | output | 1 | Memory write strobe |
| card_io_rd | output | 1 | I/O read strobe |
| card_io_wr | output | 1 | I/O write strobe |
| card_wdata | output | 16 | Write data toward the card |
| card_wdata_oe | output | 1 | Write data output enable |
| card_rdata | input | 16 | Read data from the card |

## Verification
Count cycles from the acceptance edge, taking S as the setup count, W as the strobe length and H as the hold count. The window then covers cycles 1 to S+W+H, the strobe covers cycles S+1 to S+W, rsp_ack falls in cycle S+W+H+1 and req_ready returns in cycle S+W+H+I+2, where I is the idle count. A reserved code acknowledges in cycle 1 and is ready in cycle 2. The bench's reference model rebuilds these indices from the programmed fields with plain integers. Between clock edges it compares every output against them in every cycle of every access, and for reads it changes the card data each cycle so that only a sample taken in cycle S+W matches.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;

    localparam int BASE_W  = 3;
    localparam int SLOW_W  = 2;
    localparam int EDGE_W  = 4;
    localparam int IDLE_W  = 3;
    localparam int EXTRA_MAX = 50;
    localparam int CNT_W   = $clog2((2 ** BASE_W) + EXTRA_MAX + (2 ** EDGE_W));

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SLOW_W-1:0] slow;
        logic [EDGE_W-1:0] setup;
        logic [EDGE_W-1:0] hold;
    } tset_t;

    typedef struct packed {
        logic ok;
        logic io;
        logic attr;
        logic wide;
    } space_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE,
        ST_GAP
    } phase_e;

    function automatic logic [CNT_W-1:0] slow_extra(input logic [SLOW_W-1:0] code);
        logic [CNT_W-1:0] v;
        case (code)
            2'd0:    v = CNT_W'(0);
            2'd1:    v = CNT_W'(15);
            2'd2:    v = CNT_W'(30);
            default: v = CNT_W'(EXTRA_MAX);
        endcase
        return v;
    endfunction

    // counter load for the strobe: length minus one
    function automatic logic [CNT_W-1:0] strobe_last(input tset_t t);
        return CNT_W'(t.base) + slow_extra(t.slow);
    endfunction

    function automatic space_t decode_space(input logic [2:0] code);
        space_t s;
        s.ok   = (code != 3'b000);
        s.io   = (code[2] == 1'b0);
        s.attr = (code[2:1] == 2'b11);
        s.wide = code[0];
        return s;
    endfunction

endpackage

// File: rtl/card_space_decode.sv
module card_space_decode
    import card_bus_pkg::*;
(
    input  logic [2:0] space_code,
    output space_t     info
);

    always_comb begin
        info = decode_space(space_code);
    end

endmodule

// File: rtl/card_timing_select.sv
module card_timing_select
    import card_bus_pkg::*;
(
    input  tset_t              set_a,
    input  tset_t              set_b,
    input  logic [IDLE_W-1:0]  idle_a,
    input  logic [IDLE_W-1:0]  idle_b,
    input  logic               tsel,
    input  logic               area,
    output tset_t              tim,
    output logic [IDLE_W-1:0]  idle
);

    // strobe-related fields follow the select bit, the gap follows the area
    always_comb begin
        tim  = tsel ? set_b : set_a;
        idle = area ? idle_b : idle_a;
    end

endmodule

// File: rtl/card_cycle_fsm.sv
module card_cycle_fsm
    import card_bus_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  space_t            info,
    input  tset_t             tim,
    input  logic [IDLE_W-1:0] idle,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              req_ready,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output phase_e            phase,
    output space_t            info_q,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    logic [CNT_W-1:0]  cnt;
    tset_t             tim_q;
    logic [IDLE_W-1:0] idle_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= ST_IDLE;
            cnt     <= '0;
            tim_q   <= '0;
            idle_q  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            info_q  <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        info_q  <= info;
                        tim_q   <= tim;
                        idle_q  <= idle;
                        if (!info.ok) begin
                            err_q <= 1'b1;
                            phase <= ST_DONE;
                        end else if (tim.setup != '0) begin
                            phase <= ST_SETUP;
                            cnt   <= CNT_W'(tim.setup) - 1'b1;
                        end else begin
                            phase <= ST_STROBE;
                            cnt   <= strobe_last(tim);
                        end
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        phase <= ST_STROBE;
                        cnt   <= strobe_last(tim_q);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        if (!write_q) begin
                            rdata_q <= bus_rdata;
                        end
                        if (tim_q.hold != '0) begin
                            phase <= ST_HOLD;
                            cnt   <= CNT_W'(tim_q.hold) - 1'b1;
                        end else begin
                            phase <= ST_DONE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        phase <= ST_DONE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DONE: begin
                    err_q <= 1'b0;
                    if (!err_q && idle_q != '0) begin
                        phase <= ST_GAP;
                        cnt   <= CNT_W'(idle_q) - 1'b1;
                    end else begin
                        phase <= ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) begin
                        phase <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (phase == ST_IDLE);
    assign rsp_ack   = (phase == ST_DONE);
    assign rsp_err   = (phase == ST_DONE) && err_q;
    assign rsp_rdata = rdata_q;

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_ack |=> !rsp_ack);                                         // R11
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_ack);                                          // R12
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                      // R9
    AST_CTX_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase != ST_IDLE && $past(phase) != ST_IDLE) |-> $stable(addr_q)); // R6

endmodule

// File: rtl/card_pin_drive.sv
module card_pin_drive
    import card_bus_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  phase_e            phase,
    input  space_t            info_q,
    input  logic              write_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [ADDR_W-1:0] card_addr,
    output logic              card_cs,
    output logic              card_en_lo,
    output logic              card_en_hi,
    output logic              card_reg,
    output logic              card_mem_rd,
    output logic              card_mem_wr,
    output logic              card_io_rd,
    output logic              card_io_wr,
    output logic [DATA_W-1:0] card_wdata,
    output logic              card_wdata_oe
);

    logic window;
    logic strobe;

    always_comb begin
        window = info_q.ok &&
                 (phase == ST_SETUP || phase == ST_STROBE || phase == ST_HOLD);
        strobe = info_q.ok && (phase == ST_STROBE);

        card_addr     = addr_q;
        card_cs       = window;
        card_en_lo    = window;
        card_en_hi    = window && info_q.wide;
        card_reg      = window && info_q.attr;
        card_mem_rd   = strobe && !info_q.io && !write_q;
        card_mem_wr   = strobe && !info_q.io &&  write_q;
        card_io_rd    = strobe &&  info_q.io && !write_q;
        card_io_wr    = strobe &&  info_q.io &&  write_q;
        card_wdata    = wdata_q;
        card_wdata_oe = window && write_q;
    end

endmodule

// File: rtl/card_cycle_ctrl.sv
module card_cycle_ctrl
    import card_bus_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] cfg_a_base,
    input  logic [SLOW_W-1:0] cfg_a_slow,
    input  logic [EDGE_W-1:0] cfg_a_setup,
    input  logic [EDGE_W-1:0] cfg_a_hold,
    input  logic [IDLE_W-1:0] cfg_a_idle,
    input  logic [BASE_W-1:0] cfg_b_base,
    input  logic [SLOW_W-1:0] cfg_b_slow,
    input  logic [EDGE_W-1:0] cfg_b_setup,
    input  logic [EDGE_W-1:0] cfg_b_hold,
    input  logic [IDLE_W-1:0] cfg_b_idle,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [2:0]        req_space,
    input  logic              req_tsel,
    input  logic              req_area,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] card_addr,
    output logic              card_cs,
    output logic              card_en_lo,
    output logic              card_en_hi,
    output logic              card_reg,
    output logic              card_mem_rd,
    output logic              card_mem_wr,
    output logic              card_io_rd,
    output logic              card_io_wr,
    output logic [DATA_W-1:0] card_wdata,
    output logic              card_wdata_oe,
    input  logic [DATA_W-1:0] card_rdata
);

    space_t            info;
    space_t            info_q;
    tset_t             set_a;
    tset_t             set_b;
    tset_t             tim;
    logic [IDLE_W-1:0] idle;
    phase_e            phase;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign set_a = '{base: cfg_a_base, slow: cfg_a_slow, setup: cfg_a_setup, hold: cfg_a_hold};
    assign set_b = '{base: cfg_b_base, slow: cfg_b_slow, setup: cfg_b_setup, hold: cfg_b_hold};

    card_space_decode u_decode (
        .space_code (req_space),
        .info       (info)
    );

    card_timing_select u_tsel (
        .set_a  (set_a),
        .set_b  (set_b),
        .idle_a (cfg_a_idle),
        .idle_b (cfg_b_idle),
        .tsel   (req_tsel),
        .area   (req_area),
        .tim    (tim),
        .idle   (idle)
    );

    card_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .info      (info),
        .tim       (tim),
        .idle      (idle),
        .bus_rdata (card_rdata),
        .req_ready (req_ready),
        .rsp_ack   (rsp_ack),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .phase     (phase),
        .info_q    (info_q),
        .write_q   (write_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    card_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase         (phase),
        .info_q        (info_q),
        .write_q       (write_q),
        .addr_q        (addr_q),
        .wdata_q       (wdata_q),
        .card_addr     (card_addr),
        .card_cs       (card_cs),
        .card_en_lo    (card_en_lo),
        .card_en_hi    (card_en_hi),
        .card_reg      (card_reg),
        .card_mem_rd   (card_mem_rd),
        .card_mem_wr   (card_mem_wr),
        .card_io_rd    (card_io_rd),
        .card_io_wr    (card_io_wr),
        .card_wdata    (card_wdata),
        .card_wdata_oe (card_wdata_oe)
    );

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({card_mem_rd, card_mem_wr, card_io_rd, card_io_wr}));   // R4
    AST_STROBE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (card_mem_rd || card_mem_wr || card_io_rd || card_io_wr) |-> card_cs); // R6
    AST_REG_NOT_IO: assert property (@(posedge clk) disable iff (rst)
        card_reg |-> !(card_io_rd || card_io_wr));                        // R3
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !card_cs);                                            // R12
    AST_OE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        card_wdata_oe |-> !(card_mem_rd || card_io_rd));                  // R13

endmodule

// File: tb/card_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module card_cycle_ctrl_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic [2:0]  cfg_a_base, cfg_b_base;
    logic [1:0]  cfg_a_slow, cfg_b_slow;
    logic [3:0]  cfg_a_setup, cfg_b_setup, cfg_a_hold, cfg_b_hold;
    logic [2:0]  cfg_a_idle, cfg_b_idle;
    logic        req_valid, req_ready, req_write, req_tsel, req_area;
    logic [25:0] req_addr, card_addr;
    logic [2:0]  req_space;
    logic [15:0] req_wdata, rsp_rdata, card_wdata, card_rdata;
    logic        rsp_ack, rsp_err, card_cs, card_en_lo, card_en_hi, card_reg;
    logic        card_mem_rd, card_mem_wr, card_io_rd, card_io_wr, card_wdata_oe;

    int total = 0;
    int bad   = 0;

    card_cycle_ctrl u_card_cycle_ctrl (
        .clk(clk), .rst(rst),
        .cfg_a_base(cfg_a_base), .cfg_a_slow(cfg_a_slow), .cfg_a_setup(cfg_a_setup),
        .cfg_a_hold(cfg_a_hold), .cfg_a_idle(cfg_a_idle),
        .cfg_b_base(cfg_b_base), .cfg_b_slow(cfg_b_slow), .cfg_b_setup(cfg_b_setup),
        .cfg_b_hold(cfg_b_hold), .cfg_b_idle(cfg_b_idle),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_space(req_space), .req_tsel(req_tsel),
        .req_area(req_area), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .card_addr(card_addr), .card_cs(card_cs), .card_en_lo(card_en_lo),
        .card_en_hi(card_en_hi), .card_reg(card_reg),
        .card_mem_rd(card_mem_rd), .card_mem_wr(card_mem_wr),
        .card_io_rd(card_io_rd), .card_io_wr(card_io_wr),
        .card_wdata(card_wdata), .card_wdata_oe(card_wdata_oe),
        .card_rdata(card_rdata)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                       input string tag, input string what, input int cyc);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, got, exp);
        end
    endtask

    function automatic int extra_of(input int code);
        case (code)
            0: return 0;
            1: return 15;
            2: return 30;
            default: return 50;
        endcase
    endfunction

    // behavioural reference: integer cycle indices counted from the accept edge
    task automatic run_access(input logic [25:0] a, input logic w, input logic [2:0] sp,
                              input logic t, input logic ar, input logic [15:0] wd);
        int s_n, w_n, h_n, i_n, last, ack_at;
        bit ok, io, wide, attr;
        logic [15:0] exp_rd;
        ok   = (sp != 3'b000);
        io   = (sp[2] == 1'b0);
        wide = sp[0];
        attr = (sp[2:1] == 2'b11);
        s_n  = t ? int'(cfg_b_setup) : int'(cfg_a_setup);                // R8
        h_n  = t ? int'(cfg_b_hold)  : int'(cfg_a_hold);
        w_n  = 1 + (t ? int'(cfg_b_base) : int'(cfg_a_base))
                 + extra_of(t ? int'(cfg_b_slow) : int'(cfg_a_slow));
        i_n  = ar ? int'(cfg_b_idle) : int'(cfg_a_idle);                 // R9
        if (ok) begin
            ack_at = s_n + w_n + h_n + 1;
            last   = s_n + w_n + h_n + i_n + 2;
        end else begin
            ack_at = 1;
            last   = 2;
        end
        exp_rd = 16'hA000 + 16'(s_n + w_n);
        chk(req_ready, 1'b1, "R9", "ready before request", 0);
        req_valid = 1'b1; req_addr = a; req_write = w; req_space = sp;
        req_tsel = t; req_area = ar; req_wdata = wd;
        for (int k = 1; k <= last; k++) begin
            bit win, stb;
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            win = ok && (k <= s_n + w_n + h_n);
            stb = ok && (k > s_n) && (k <= s_n + w_n);
            chk(card_cs, win, (k <= s_n) ? "R6" : ((k > s_n + w_n) ? "R7" : "R5"), "cs window", k);
            chk(card_en_lo, win, "R2", "en_lo", k);
            chk(card_en_hi, win && wide, "R2", "en_hi", k);
            chk(card_reg, win && attr, "R3", "reg select", k);
            chk(card_mem_rd, stb && !io && !w, "R5", "mem_rd strobe", k);
            chk(card_mem_wr, stb && !io && w, "R4", "mem_wr strobe", k);
            chk(card_io_rd, stb && io && !w, "R4", "io_rd strobe", k);
            chk(card_io_wr, stb && io && w, "R5", "io_wr strobe", k);
            chk(card_wdata_oe, win && w, "R13", "wdata oe", k);
            if (win) chk(card_addr, a, "R6", "address", k);
            if (win && w) chk(card_wdata, wd, "R13", "write data", k);
            chk(rsp_ack, k == ack_at, "R11", "ack", k);
            chk(rsp_err, (k == ack_at) && !ok, ok ? "R11" : "R12", "err", k);
            if (k == ack_at && ok && !w) chk(rsp_rdata, exp_rd, "R10", "read data", k);
            chk(req_ready, k == last, "R9", "ready", k);
            card_rdata = 16'hA000 + 16'(k);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_space = 3'b000; req_tsel = 1'b0; req_area = 1'b0; req_wdata = '0;
        card_rdata = '0;
        cfg_a_base = 3'd2; cfg_a_slow = 2'd0; cfg_a_setup = 4'd1; cfg_a_hold = 4'd1; cfg_a_idle = 3'd2;
        cfg_b_base = 3'd0; cfg_b_slow = 2'd1; cfg_b_setup = 4'd3; cfg_b_hold = 4'd0; cfg_b_idle = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready, 1'b1, "R1", "ready in reset", 0);
        chk({rsp_ack, rsp_err, card_cs, card_en_lo, card_en_hi, card_reg, card_wdata_oe,
             card_mem_rd, card_mem_wr, card_io_rd, card_io_wr}, 0, "R1", "outputs in reset", 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, 1'b1, "R1", "ready after reset", 0);
        chk({rsp_ack, card_cs, card_mem_rd, card_io_rd}, 0, "R1", "quiet after reset", 0);

        run_access(26'h0123456, 1'b0, 3'b101, 1'b0, 1'b0, 16'h0000); // 16-bit common read, set A
        run_access(26'h3ABCDE0, 1'b1, 3'b110, 1'b1, 1'b0, 16'h5A5A); // attr write, timing B, gap A (R8, R9)
        run_access(26'h0000011, 1'b0, 3'b010, 1'b0, 1'b1, 16'h0000); // 8-bit I/O read, gap B
        run_access(26'h1111111, 1'b1, 3'b000, 1'b0, 1'b0, 16'hFFFF); // reserved code (R12)
        run_access(26'h0222222, 1'b1, 3'b001, 1'b1, 1'b1, 16'hC3C3); // dynamic I/O write
        run_access(26'h0333333, 1'b1, 3'b011, 1'b0, 1'b1, 16'h1234); // 16-bit I/O write

        cfg_a_base = 3'd7; cfg_a_slow = 2'd2; cfg_a_setup = 4'd0; cfg_a_hold = 4'd0; cfg_a_idle = 3'd7;
        cfg_b_base = 3'd5; cfg_b_slow = 2'd3; cfg_b_setup = 4'd15; cfg_b_hold = 4'd15; cfg_b_idle = 3'd1;
        run_access(26'h0444444, 1'b0, 3'b111, 1'b0, 1'b1, 16'h0000); // zero setup/hold, code 2
        run_access(26'h0555555, 1'b0, 3'b100, 1'b1, 1'b0, 16'h0000); // max setup/hold, code 3
        run_access(26'h0666666, 1'b1, 3'b101, 1'b1, 1'b0, 16'h8001); // common write, set B
        run_access(26'h0777777, 1'b0, 3'b011, 1'b0, 1'b0, 16'h0000); // 16-bit I/O read, set A

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule